// File: doc/BRIEF.md
# Absolute-Address Add-With-Carry Sequencer

This block is the multi-cycle control and datapath slice of a small accumulator machine that carries out a single instruction: the byte held at a full-width absolute memory address is added to the accumulator, and the stored carry flag is added in as well. The block has a byte-wide read data bus, a wide address bus and a read strobe. Internally it keeps a program counter, an address-assembly register, a memory address register, a memory data register, the accumulator and a small flag set.

Each instruction starts with an opcode read at the program counter. A recognised opcode is followed by the address operand, which arrives as a series of byte reads at successive program-counter values, lowest byte first. The assembled address then drives one more read that returns the data byte. In the final cycle the sum is written back, the flags are updated, and a one-cycle done pulse is raised. An opcode the block does not know sends it straight back to the next opcode read and leaves the accumulator and flags untouched.

Memory answers every strobe one cycle later, and the sequencer waits one state for each read. A synchronous reset clears the accumulator and the flags, and loads the program counter from the reset-vector input.

Top module: `adc_abs_seq`

## Requirements
- R1: While `rst` is high on a clock edge, `acc` and all `flags` bits become 0 and the program counter is loaded from `rstVector`. The first cycle after reset is an opcode read with `memRd`=1 and `memAddr`=`rstVector`.
- R2: An opcode read asserts `memRd` for one cycle with the program counter on `memAddr` and advances the program counter by 1. The next cycle is a wait cycle with `memRd`=0, and the opcode is taken from `memRdata` at the end of that wait cycle.
- R3: For opcode `ADC_OP` (default 8'h5B), the two address bytes are read at the two program-counter values after the opcode, each read followed by one wait cycle. The first byte is address bits [7:0] and the second byte is address bits [15:8].
- R4: After the address bytes, one read is issued with `memAddr` equal to the assembled address, followed by one wait cycle that captures the data byte.
- R5: The cycle after the data wait cycle is the execute cycle. At its end `acc` becomes (acc + data + carry) mod 256, where carry is `flags[0]`. `acc` and `flags` change at no other time.
- R6: In the execute cycle, `flags[0]` (carry) takes bit 8 of the 9-bit sum acc + data + carry.
- R7: In the execute cycle, `flags[1]` (zero) is set when the 8-bit result is 0, `flags[2]` (negative) takes result bit 7, and `flags[3]` (overflow) is set when acc and data have the same bit 7 and the result's bit 7 differs from it.
- R8: `done` is high only during the execute cycle, for exactly one cycle, with `memRd`=0. The next cycle is an opcode read. An add instruction takes 9 cycles in total.
- R9: Any opcode other than `ADC_OP` takes 2 cycles (read and wait), leaves `acc` and `flags` unchanged, raises no `done`, and is followed by an opcode read at the next address.
- R10: The program counter wraps from 16'hFFFF to 16'h0000 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rstVector | input | 16 | Program counter value loaded while in reset |
| memRdata | input | 8 | Read data, valid the cycle after a strobe |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read strobe |
| acc | output | 8 | Accumulator |
| flags | output | 4 | Bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow |
| done | output | 1 | One-cycle pulse in the execute cycle |

## Verification
The bench builds the block with its default widths: an 8-bit data bus and a 16-bit address, which means two operand bytes per add and the default opcode. With 16-bit addresses, a reset vector of 16'hFFFE lets an instruction's operand bytes cross the wrap to 16'h0000. With 8-bit data, hand-picked operands can reach the signed-overflow, carry-out, zero-result and carry-in cases, and can set the high and low address bytes to clearly different values. Unknown opcodes, including one that differs from the add opcode in a single bit, are mixed in among the adds.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OP_RD,
    ST_OP_WT,
    ST_AD_RD,
    ST_AD_WT,
    ST_DA_RD,
    ST_DA_WT,
    ST_EXEC
  } seqState_t;

  typedef struct packed {
    logic memRead;
    logic useMar;
    logic pcInc;
    logic shiftAddr;
    logic loadMar;
    logic loadMdr;
    logic exec;
  } ctrlStrobe_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_W = 4;

endpackage

// File: rtl/adc_seq_alu.sv
module adc_seq_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sum,
  output logic              carryOut,
  output logic              overflow
);

  logic [DATA_W:0] chain;

  always_comb begin
    chain[0] = carryIn;
    for (int i = 0; i < DATA_W; i++) begin
      sum[i]       = opA[i] ^ opB[i] ^ chain[i];
      chain[i + 1] = (opA[i] & opB[i]) | (chain[i] & (opA[i] ^ opB[i]));
    end
  end

  assign carryOut = chain[DATA_W];
  assign overflow = chain[DATA_W] ^ chain[DATA_W - 1];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        opIsAdc,
  output ctrlStrobe_t strobe,
  output logic        done
);

  localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(ADDR_BYTES - 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] byteCnt;
  logic lastByte;

  assign lastByte = (byteCnt == LAST_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OP_RD;
      byteCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_AD_WT) begin
        byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
      end
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_OP_RD: nextState = ST_OP_WT;
      ST_OP_WT: nextState = opIsAdc ? ST_AD_RD : ST_OP_RD;
      ST_AD_RD: nextState = ST_AD_WT;
      ST_AD_WT: nextState = lastByte ? ST_DA_RD : ST_AD_RD;
      ST_DA_RD: nextState = ST_DA_WT;
      ST_DA_WT: nextState = ST_EXEC;
      ST_EXEC:  nextState = ST_OP_RD;
      default:  nextState = ST_OP_RD;
    endcase
  end

  always_comb begin
    strobe.memRead   = (state == ST_OP_RD) || (state == ST_AD_RD) || (state == ST_DA_RD);
    strobe.useMar    = (state == ST_DA_RD);
    strobe.pcInc     = (state == ST_OP_RD) || (state == ST_AD_RD);
    strobe.shiftAddr = (state == ST_AD_WT);
    strobe.loadMar   = (state == ST_AD_WT) && lastByte;
    strobe.loadMdr   = (state == ST_DA_WT);
    strobe.exec      = (state == ST_EXEC);
  end

  assign done = (state == ST_EXEC);

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter int               ADDR_W = 16,
  parameter logic [DATA_W-1:0] ADC_OP = 8'h5B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rstVector,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              opIsAdc,
  output logic [DATA_W-1:0] acc,
  output logic [FLAG_W-1:0] flags
);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] marReg;
  logic [ADDR_W-1:0] addrAsm;
  logic [ADDR_W-1:0] addrShifted;
  logic [DATA_W-1:0] mdrReg;
  logic [DATA_W-1:0] accReg;
  logic [FLAG_W-1:0] flagReg;
  logic [DATA_W-1:0] aluSum;
  logic              aluCarry;
  logic              aluOvf;

  assign addrShifted = {memRdata, addrAsm[ADDR_W-1:DATA_W]};
  assign opIsAdc     = (memRdata == ADC_OP);
  assign memAddr     = strobe.useMar ? marReg : pcReg;
  assign memRd       = strobe.memRead;

  adc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .opA      (accReg),
    .opB      (mdrReg),
    .carryIn  (flagReg[FLAG_C]),
    .sum      (aluSum),
    .carryOut (aluCarry),
    .overflow (aluOvf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg   <= rstVector;
      marReg  <= '0;
      addrAsm <= '0;
      mdrReg  <= '0;
      accReg  <= '0;
      flagReg <= '0;
    end else begin
      if (strobe.pcInc)     pcReg   <= pcReg + 1'b1;
      if (strobe.shiftAddr) addrAsm <= addrShifted;
      if (strobe.loadMar)   marReg  <= addrShifted;
      if (strobe.loadMdr)   mdrReg  <= memRdata;
      if (strobe.exec) begin
        accReg          <= aluSum;
        flagReg[FLAG_C] <= aluCarry;
        flagReg[FLAG_Z] <= (aluSum == '0);
        flagReg[FLAG_N] <= aluSum[DATA_W-1];
        flagReg[FLAG_V] <= aluOvf;
      end
    end
  end

  assign acc   = accReg;
  assign flags = flagReg;

endmodule

// File: rtl/adc_abs_seq.sv
module adc_abs_seq
  import adc_seq_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter int               ADDR_W = 16,
  parameter logic [DATA_W-1:0] ADC_OP = 8'h5B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rstVector,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic [DATA_W-1:0] acc,
  output logic [FLAG_W-1:0] flags,
  output logic              done
);

  localparam int ADDR_BYTES = ADDR_W / DATA_W;

  ctrlStrobe_t strobe;
  logic        opIsAdc;

  adc_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opIsAdc (opIsAdc),
    .strobe  (strobe),
    .done    (done)
  );

  adc_seq_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .ADC_OP (ADC_OP)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rstVector (rstVector),
    .strobe    (strobe),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memRd     (memRd),
    .opIsAdc   (opIsAdc),
    .acc       (acc),
    .flags     (flags)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int FLG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rstVector,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic [DATA_W-1:0] acc,
  input logic [FLG_W-1:0]  flags,
  input logic              done
);

  // R1: reset clears accumulator and flags and points the first read at the vector
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && flags == '0 && memRd && memAddr == $past(rstVector)));

  // R2: every read strobe is followed by a wait cycle
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
    memRd |=> !memRd);

  // R5: accumulator and flags move only at the end of an execute cycle
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(acc) && $stable(flags)));

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: no read in the execute cycle
  p_done_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !memRd);

  // R8: an opcode read follows the execute cycle
  p_fetch_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> memRd);

endmodule

bind adc_abs_seq adc_seq_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .FLG_W  (adc_seq_pkg::FLAG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rstVector (rstVector),
  .memAddr   (memAddr),
  .memRd     (memRd),
  .acc       (acc),
  .flags     (flags),
  .done      (done)
);

// File: tb/adc_abs_seq_bench.sv
`timescale 1ns/1ps
module adc_abs_seq_bench;

  localparam bit [7:0] OP = 8'h5B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rstVector = 16'h1200;
  logic [7:0]  memRdata = 8'h00;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  acc;
  logic [3:0]  flags;
  logic        done;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  adc_abs_seq u_adc_abs_seq (
    .clk(clk), .rst(rst), .rstVector(rstVector), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .acc(acc), .flags(flags), .done(done)
  );

  // memory: data for a strobe appears during the following cycle
  bit [7:0]  mem [65536];
  bit        rdPend = 1'b0;
  bit [15:0] pendAddr = 16'h0;
  always @(negedge clk) begin
    memRdata <= rdPend ? mem[pendAddr] : 8'h00;
    rdPend   <= memRd;
    pendAddr <= memAddr;
  end

  typedef struct {
    bit        rd;
    bit [15:0] addr;
    bit [7:0]  acc;
    bit [3:0]  flg;
    bit        done;
    string     tA;
    string     tV;
  } exp_t;
  exp_t q[$];

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic push(bit rd, bit [15:0] a, bit [7:0] ac, bit [3:0] f, bit d, string tA, string tV);
    exp_t e;
    e.rd = rd; e.addr = a; e.acc = ac; e.flg = f; e.done = d; e.tA = tA; e.tV = tV;
    q.push_back(e);
  endtask

  task automatic putAdc(inout bit [15:0] pc, input bit [15:0] ea, input bit [7:0] data);
    mem[pc] = OP; pc = pc + 1;
    mem[pc] = ea[7:0]; pc = pc + 1;
    mem[pc] = ea[15:8]; pc = pc + 1;
    mem[ea] = data;
  endtask

  task automatic putOther(inout bit [15:0] pc, input bit [7:0] op);
    mem[pc] = op; pc = pc + 1;
  endtask

  // behavioural reference: walks memory instruction by instruction
  task automatic buildModel(input bit [15:0] vec, input int nInstr, input bit wrapTag);
    bit [15:0] pc = vec;
    bit [7:0]  a = 8'h00;
    bit [3:0]  f = 4'h0;
    string     tV = "R1";
    string     tA;
    for (int n = 0; n < nInstr; n++) begin
      bit [7:0] op = mem[pc];
      tA = wrapTag ? "R10" : "R2";
      push(1, pc, a, f, 0, tA, tV);
      push(0, 0, a, f, 0, "R2", tV);
      pc = pc + 1;
      if (op == OP) begin
        bit [7:0] lo, hi, d;
        bit [15:0] ea;
        int s;
        bit [7:0] r;
        lo = mem[pc];
        push(1, pc, a, f, 0, wrapTag ? "R10" : "R3", tV);
        push(0, 0, a, f, 0, "R3", tV);
        pc = pc + 1;
        hi = mem[pc];
        push(1, pc, a, f, 0, wrapTag ? "R10" : "R3", tV);
        push(0, 0, a, f, 0, "R3", tV);
        pc = pc + 1;
        ea = {hi, lo};
        d = mem[ea];
        push(1, ea, a, f, 0, "R4", tV);
        push(0, 0, a, f, 0, "R4", tV);
        push(0, 0, a, f, 1, "R8", tV);
        s = int'(a) + int'(d) + int'(f[0]);
        r = s[7:0];
        f[0] = s[8];
        f[1] = (r == 8'h00);
        f[2] = r[7];
        f[3] = (a[7] == d[7]) && (r[7] != a[7]);
        a = r;
        tV = "R5";
      end else begin
        tV = "R9";
      end
    end
    push(1, pc, a, f, 0, wrapTag ? "R10" : "R2", tV);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compareCycle(exp_t e);
    string cTag, fTag;
    cTag = (e.tV == "R5") ? "R6" : e.tV;
    fTag = (e.tV == "R5") ? "R7" : e.tV;
    check(memRd == e.rd, e.tA, "memRd", int'(memRd), int'(e.rd));
    if (e.rd) check(memAddr == e.addr, e.tA, "memAddr", int'(memAddr), int'(e.addr));
    check(acc == e.acc, e.tV, "acc", int'(acc), int'(e.acc));
    check(flags[0] == e.flg[0], cTag, "carry", int'(flags[0]), int'(e.flg[0]));
    check(flags[3:1] == e.flg[3:1], fTag, "znv", int'(flags[3:1]), int'(e.flg[3:1]));
    check(done == e.done, "R8", "done", int'(done), int'(e.done));
  endtask

  task automatic runPhase(bit [15:0] vec, int nInstr, bit wrapTag);
    rst = 1'b1;
    rstVector = vec;
    q.delete();
    buildModel(vec, nInstr, wrapTag);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      compareCycle(e);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit [15:0] pc;
    for (int i = 0; i < 65536; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
    // phase 1 program
    pc = 16'h1200;
    putAdc(pc, 16'hABCD, 8'h7F);   // R5 plain add
    putAdc(pc, 16'h00FF, 8'h01);   // R7 signed overflow, negative
    putOther(pc, 8'h00);           // R9
    putAdc(pc, 16'hFF00, 8'h80);   // R6 carry out, zero, overflow
    putAdc(pc, 16'h3412, 8'h05);   // R5 carry in used
    putOther(pc, 8'hFF);           // R9
    putAdc(pc, 16'h8001, 8'hFF);   // R6 carry out
    putAdc(pc, 16'h8002, 8'h00);   // R5 carry in
    putOther(pc, 8'h5A);           // R9 opcode one bit away
    for (int k = 0; k < 20; k++) begin
      bit [15:0] ea = 16'h4000 | 16'(nextRand() & 32'h3FFF);
      putAdc(pc, ea, 8'(nextRand()));
    end
    runPhase(16'h1200, 29, 1'b0);
    // phase 2: operand bytes cross the address wrap (R10) and reset clears state (R1)
    pc = 16'hFFFE;
    putAdc(pc, 16'h9010, 8'h33);
    putAdc(pc, 16'h9011, 8'hCD);
    runPhase(16'hFFFE, 2, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule